// File: doc/BRIEF.md
# Per-Pixel Shading Normaliser

This block flattens uneven illumination and uneven sensor response along a scan line. Each pixel position on the line owns a white reference value. Every live 8-bit pixel is divided by the reference stored for its position, and the quotient is scaled back to full scale. The division is exact, not a table approximation. The block works in two phases that share one pixel stream. A capture line writes the white references into an internal line store. A correction line reads the stored references and emits normalised pixels.

Pixels enter on a valid/ready stream. A line-start flag marks the first beat of each line, and a calibration-select level decides what happens to that line. Results leave on a second valid/ready stream, in the order the pixels were accepted. Back-pressure works as follows. When `out_valid` is high and `out_ready` is low, the output holds its value, the whole divider pipeline freezes, and `in_ready` drops. An input beat counts as taken only in a cycle where `in_valid` and `in_ready` are both high. The reference index width is a parameter: a value of 13 covers 8192-pixel lines, and the default of 11 covers 2048-pixel lines.

As the reference drops lower in the converter range, the gain grows, so the result keeps fewer significant bits. References below one sixteenth of full scale are outside the range the block can correct, and those pixels saturate.

Top module: `shading_normalizer`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: A line whose first beat (`in_sol`=1) is taken while `cal_mode` is high is a capture line. Its pixel k is stored as the reference for position k, counted from 0 at the line-start beat, and the line produces no output beats.
- R3: The block samples `cal_mode` only on the line-start beat. If `cal_mode` rises partway through a correction line, that line is still corrected in full and the stored references are left unchanged.
- R4: Before the precision step, a correction beat computes q = min(255, floor(pixel*255/ref)) from the reference stored at its position.
- R5: If ref >= 64, the output is q with its two least significant bits cleared. This applies to a saturated q as well, giving 252.
- R6: If 32 <= ref <= 63, the output is q with its three least significant bits cleared.
- R7: If 16 <= ref <= 31, the output is q with its four least significant bits cleared.
- R8: If ref < 16, including ref = 0, the output is 255 whatever the pixel value.
- R9: With `out_ready` held high, a correction result first shows on the output after the 8th rising edge that follows the edge that accepted its pixel. Results leave in acceptance order.
- R10: While `out_valid` is high and `out_ready` is low, `out_pix` and `out_valid` hold and `in_ready` is low. No beat is lost or duplicated under any back-pressure pattern.
- R11: The position counter restarts at 0 on every line-start beat, including one that cuts a line short.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cal_mode | input | 1 | Calibration select, sampled on line-start beats |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take an input beat |
| in_sol | input | 1 | Beat is the first pixel of a line |
| in_pix | input | 8 | Input pixel sample |
| out_valid | output | 1 | Corrected pixel present |
| out_ready | input | 1 | Downstream takes the corrected pixel |
| out_pix | output | 8 | Corrected pixel |

## Verification
A bad position counter or a wrong capture flag shows up on the first beat of the next correction line: a pixel is divided by a neighbour's reference, or a capture line leaks output beats. A fault in a divider stage corrupts a single quotient bit. Such a fault surfaces 8 edges after acceptance, and clean references in the high band hide it less well than the coarse bands do. Pipeline-advance faults show as a lost beat, a repeated beat or an output that changes while stalled, and only when back-pressure is applied. For that reason the random lines run with a toggling `out_ready`.

// File: rtl/shn_pkg.sv
package shn_pkg;

  localparam int SHN_PIX_W = 8;
  localparam int SHN_NUM_W = 2 * SHN_PIX_W;
  localparam logic [SHN_PIX_W-1:0] SHN_FULL = '1;
  // band limits: full-scale / 4, / 8, / 16
  localparam logic [SHN_PIX_W-1:0] SHN_LIM_FINE   = SHN_PIX_W'(1 << (SHN_PIX_W - 2));
  localparam logic [SHN_PIX_W-1:0] SHN_LIM_MID    = SHN_PIX_W'(1 << (SHN_PIX_W - 3));
  localparam logic [SHN_PIX_W-1:0] SHN_LIM_COARSE = SHN_PIX_W'(1 << (SHN_PIX_W - 4));

  typedef enum logic [1:0] {
    GR_FINE,
    GR_MID,
    GR_COARSE,
    GR_FLAT
  } shn_grade_e;

  typedef struct packed {
    logic                 live;
    logic                 full;
    shn_grade_e           grade;
    logic [SHN_PIX_W-1:0] refv;
    logic [SHN_PIX_W-1:0] rem;
    logic [SHN_PIX_W-1:0] lo;
    logic [SHN_PIX_W-1:0] quo;
  } shn_stage_t;

  function automatic shn_grade_e shn_grade_of(input logic [SHN_PIX_W-1:0] refv);
    shn_grade_e g;
    if (refv >= SHN_LIM_FINE)        g = GR_FINE;
    else if (refv >= SHN_LIM_MID)    g = GR_MID;
    else if (refv >= SHN_LIM_COARSE) g = GR_COARSE;
    else                             g = GR_FLAT;
    return g;
  endfunction

  // numerator = pixel * full-scale; the high half below ref means the quotient fits
  function automatic shn_stage_t shn_setup(input logic live,
                                           input logic [SHN_PIX_W-1:0] pix,
                                           input logic [SHN_PIX_W-1:0] refv);
    shn_stage_t s;
    logic [SHN_NUM_W-1:0] num;
    num     = SHN_NUM_W'(pix) * SHN_NUM_W'(SHN_FULL);
    s.live  = live;
    s.grade = shn_grade_of(refv);
    s.refv  = refv;
    s.full  = (s.grade == GR_FLAT) || (num[SHN_NUM_W-1:SHN_PIX_W] >= refv);
    s.rem   = s.full ? '0 : num[SHN_NUM_W-1:SHN_PIX_W];
    s.lo    = num[SHN_PIX_W-1:0];
    s.quo   = '0;
    return s;
  endfunction

  // one restoring step: one quotient bit per call
  function automatic shn_stage_t shn_step(input shn_stage_t s);
    shn_stage_t n;
    logic [SHN_PIX_W:0] trial;
    n     = s;
    trial = {s.rem, s.lo[SHN_PIX_W-1]};
    n.lo  = {s.lo[SHN_PIX_W-2:0], 1'b0};
    if (!s.full && (trial >= {1'b0, s.refv})) begin
      n.rem = SHN_PIX_W'(trial - {1'b0, s.refv});
      n.quo = {s.quo[SHN_PIX_W-2:0], 1'b1};
    end else begin
      n.rem = trial[SHN_PIX_W-1:0];
      n.quo = {s.quo[SHN_PIX_W-2:0], 1'b0};
    end
    return n;
  endfunction

  function automatic logic [SHN_PIX_W-1:0] shn_finish(input shn_stage_t s);
    logic [SHN_PIX_W-1:0] base;
    logic [SHN_PIX_W-1:0] res;
    base = s.full ? SHN_FULL : s.quo;
    case (s.grade)
      GR_FINE:   res = base & (SHN_FULL << (SHN_PIX_W - 6));
      GR_MID:    res = base & (SHN_FULL << (SHN_PIX_W - 5));
      GR_COARSE: res = base & (SHN_FULL << (SHN_PIX_W - 4));
      default:   res = SHN_FULL;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/shn_line_ctrl.sv
module shn_line_ctrl #(
  parameter int IDX_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             beat,
  input  logic             sol,
  input  logic             cal_mode,
  output logic [IDX_W-1:0] idx,
  output logic             wr_en,
  output logic             pix_en
);

  logic [IDX_W-1:0] next_idx;
  logic             cap_line;
  logic             cap_now;

  always_comb begin
    idx     = sol ? '0 : next_idx;
    cap_now = sol ? cal_mode : cap_line;
    wr_en   = beat && cap_now;
    pix_en  = beat && !cap_now;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      next_idx <= '0;
      cap_line <= 1'b0;
    end else if (beat) begin
      next_idx <= idx + 1'b1;
      cap_line <= cap_now;
    end
  end

endmodule

// File: rtl/shn_refmem.sv
module shn_refmem #(
  parameter int IDX_W = 11,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [DW-1:0]    wdata,
  input  logic             re,
  input  logic [IDX_W-1:0] raddr,
  output logic [DW-1:0]    rdata
);

  localparam int DEPTH = 1 << IDX_W;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    if (re) rdata <= cells[raddr];
  end

endmodule

// File: rtl/shn_div_pipe.sv
module shn_div_pipe
  import shn_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adv,
  input  logic                 in_live,
  input  logic [SHN_PIX_W-1:0] in_pix,
  input  logic [SHN_PIX_W-1:0] ref_i,   // arrives one cycle after in_pix
  output logic                 out_live,
  output logic [SHN_PIX_W-1:0] out_pix
);

  localparam int STAGES = SHN_PIX_W;

  logic                 s0_live;
  logic [SHN_PIX_W-1:0] s0_pix;
  shn_stage_t           st [1:STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      s0_live <= 1'b0;
      s0_pix  <= '0;
    end else if (adv) begin
      s0_live <= in_live;
      s0_pix  <= in_pix;
    end
  end

  for (genvar k = 1; k <= STAGES; k++) begin : g_stage
    if (k == 1) begin : g_head
      always_ff @(posedge clk) begin
        if (rst)      st[k] <= '0;
        else if (adv) st[k] <= shn_step(shn_setup(s0_live, s0_pix, ref_i));
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst)      st[k] <= '0;
        else if (adv) st[k] <= shn_step(st[k-1]);
      end
    end
  end

  assign out_live = st[STAGES].live;
  assign out_pix  = shn_finish(st[STAGES]);

endmodule

// File: rtl/shading_normalizer.sv
module shading_normalizer
  import shn_pkg::*;
#(
  parameter int IDX_W = 11
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cal_mode,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_sol,
  input  logic [SHN_PIX_W-1:0] in_pix,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [SHN_PIX_W-1:0] out_pix
);

  logic                 adv;
  logic                 beat;
  logic                 wr_en;
  logic                 pix_en;
  logic [IDX_W-1:0]     idx;
  logic [SHN_PIX_W-1:0] ref_q;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;
  assign beat     = in_valid && adv;

  shn_line_ctrl #(.IDX_W(IDX_W)) u_line (
    .clk      (clk),
    .rst      (rst),
    .beat     (beat),
    .sol      (in_sol),
    .cal_mode (cal_mode),
    .idx      (idx),
    .wr_en    (wr_en),
    .pix_en   (pix_en)
  );

  shn_refmem #(.IDX_W(IDX_W), .DW(SHN_PIX_W)) u_mem (
    .clk   (clk),
    .we    (wr_en),
    .waddr (idx),
    .wdata (in_pix),
    .re    (pix_en),
    .raddr (idx),
    .rdata (ref_q)
  );

  shn_div_pipe u_div (
    .clk      (clk),
    .rst      (rst),
    .adv      (adv),
    .in_live  (pix_en),
    .in_pix   (in_pix),
    .ref_i    (ref_q),
    .out_live (out_valid),
    .out_pix  (out_pix)
  );

endmodule

// File: rtl/shn_checker.sv
module shn_checker
  import shn_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 pix_en,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [SHN_PIX_W-1:0] out_pix
);

  localparam int HOLD = SHN_PIX_W + 1;
  localparam int CW   = 8;

  logic [CW-1:0] pend;

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= pend + CW'(pix_en) - CW'(out_valid && out_ready);
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid); // R1

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix))); // R10

  AST_INFLIGHT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    pend <= CW'(HOLD)); // R10

  AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (pend != '0)); // R9

  AST_BAND_GRAIN: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_pix[1:0] == 2'b00) || (out_pix == SHN_FULL))); // R5

endmodule

bind shading_normalizer shn_checker u_shn_checker (
  .clk       (clk),
  .rst       (rst),
  .pix_en    (pix_en),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_pix   (out_pix)
);

// File: tb/shading_normalizer_bench.sv
module shading_normalizer_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cal_mode = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_sol = 1'b0;
  logic [7:0] in_pix = 8'd0;
  logic       out_ready = 1'b1;
  logic       in_ready;
  logic       out_valid;
  logic [7:0] out_pix;

  shading_normalizer u_shading_normalizer (
    .clk(clk), .rst(rst), .cal_mode(cal_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_sol(in_sol), .in_pix(in_pix),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc++;

  // {pixel, reference, expected}
  localparam int NV = 13;
  localparam logic [23:0] VEC [NV] = '{
    {8'd200, 8'd250, 8'd204},
    {8'd100, 8'd200, 8'd124},
    {8'd128, 8'd128, 8'd252},
    {8'd10,  8'd40,  8'd56},
    {8'd20,  8'd20,  8'd240},
    {8'd5,   8'd20,  8'd48},
    {8'd77,  8'd10,  8'd255},
    {8'd0,   8'd100, 8'd0},
    {8'd255, 8'd0,   8'd255},
    {8'd30,  8'd16,  8'd240},
    {8'd15,  8'd31,  8'd112},
    {8'd50,  8'd63,  8'd200},
    {8'd33,  8'd64,  8'd128}
  };

  int checks = 0;
  int fails  = 0;
  logic [7:0] sd [0:255];
  int         sn;
  logic [7:0] gt [0:511];
  int         gn;
  logic [7:0] refs [0:255];
  int acc_cyc;
  int first_out_cyc;

  function automatic int model(input int p, input int r);
    int q;
    if (r < 16) return 255;
    q = (p * 255) / r;
    if (q > 255) q = 255;
    if (r >= 64)      q = q & ~3;
    else if (r >= 32) q = q & ~7;
    else              q = q & ~15;
    return q;
  endfunction

  function automatic string band_tag(input int r);
    if (r < 16) return "R8";
    if (r < 32) return "R7";
    if (r < 64) return "R6";
    return "R5";
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // one line: sd[0..sn-1], line start on beat 0; cal_mode high from beat cal_from (-1 = never)
  task automatic run_line(input int cal_from, input bit bp);
    int i = 0;
    int tail = 0;
    acc_cyc = -1;
    first_out_cyc = -1;
    while (tail < 30) begin
      @(negedge clk);
      out_ready = (bp && i < sn) ? ($urandom_range(0, 2) != 0) : 1'b1;
      cal_mode  = (cal_from >= 0) && (i >= cal_from);
      #1;
      if (out_valid && out_ready) begin
        if (first_out_cyc < 0) first_out_cyc = cyc;
        if (gn < 512) gt[gn] = out_pix;
        gn++;
      end
      if (i < sn) begin
        in_valid = 1'b1;
        in_sol   = (i == 0);
        in_pix   = sd[i];
        if (in_ready) begin
          if (i == 0) acc_cyc = cyc;
          i++;
        end
      end else begin
        in_valid = 1'b0;
        in_sol   = 1'b0;
        tail++;
      end
    end
    in_valid = 1'b0;
    cal_mode = 1'b0;
  endtask

  task automatic load_table_refs();
    for (int k = 0; k < NV; k++) begin
      sd[k]   = VEC[k][15:8];
      refs[k] = VEC[k][15:8];
    end
    sn = NV;
  endtask

  task automatic load_table_pix();
    for (int k = 0; k < NV; k++) sd[k] = VEC[k][23:16];
    sn = NV;
  endtask

  task automatic check_table_out(input int base, input string req);
    for (int k = 0; k < NV; k++)
      check(gt[base+k] == VEC[k][7:0], req, int'(gt[base+k]), int'(VEC[k][7:0]));
  endtask

  initial begin
    #(10 * 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R1", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1", int'(in_ready), 1);
    @(negedge clk);
    rst = 1'b0;

    // capture the table references, then correct the table pixels
    load_table_refs();
    gn = 0;
    run_line(0, 1'b0);
    check(gn == 0, "R2", gn, 0);
    load_table_pix();
    gn = 0;
    run_line(-1, 1'b0);
    check(gn == NV, "R4", gn, NV);
    for (int k = 0; k < NV; k++)
      check(gt[k] == VEC[k][7:0], band_tag(int'(VEC[k][15:8])), int'(gt[k]), int'(VEC[k][7:0]));

    // latency of a lone beat on an idle pipeline: accept-decision cycle to first output cycle is 8 + 1
    sd[0] = VEC[0][23:16];
    sn = 1;
    gn = 0;
    run_line(-1, 1'b0);
    check(first_out_cyc - acc_cyc == 9, "R9", first_out_cyc - acc_cyc, 9);
    check(gt[0] == VEC[0][7:0], "R9", int'(gt[0]), int'(VEC[0][7:0]));

    // cal_mode rises mid-line: line still corrected, references untouched
    load_table_pix();
    gn = 0;
    run_line(5, 1'b0);
    check(gn == NV, "R3", gn, NV);
    check_table_out(0, "R3");
    load_table_pix();
    gn = 0;
    run_line(-1, 1'b0);
    check_table_out(0, "R3");

    // short line then a full one: position restarts at the new line start
    load_table_pix();
    sn = 3;
    gn = 0;
    run_line(-1, 1'b0);
    load_table_pix();
    run_line(-1, 1'b0);
    check(gn == NV + 3, "R11", gn, NV + 3);
    for (int k = 0; k < 3; k++)
      check(gt[k] == VEC[k][7:0], "R11", int'(gt[k]), int'(VEC[k][7:0]));
    check_table_out(3, "R11");

    // random references and pixels under back-pressure
    for (int round = 0; round < 4; round++) begin
      for (int k = 0; k < 64; k++) begin
        refs[k] = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 40)) : 8'($urandom_range(0, 255));
        sd[k]   = refs[k];
      end
      sn = 64;
      gn = 0;
      run_line(0, round[0]);
      check(gn == 0, "R2", gn, 0);
      for (int k = 0; k < 64; k++) sd[k] = 8'($urandom_range(0, 255));
      gn = 0;
      run_line(-1, 1'b1);
      check(gn == 64, "R10", gn, 64);
      for (int k = 0; k < 64; k++)
        check(int'(gt[k]) == model(int'(sd[k]), int'(refs[k])), "R4 R10",
              int'(gt[k]), model(int'(sd[k]), int'(refs[k])));
    end

    report();
  end

endmodule